// File: doc/BRIEF.md
# Shared Word Memory Ownership and Address Translation

This block arbitrates a 256 KB shared memory between a main processor and a sub processor. It holds one 8-bit control byte that both processors write through their own write strobes. The byte carries the bank organisation, the ownership handshake flags and a two-bit program-memory bank number. The bank organisation is either one whole 256 KB bank or two interleaved 128 KB halves. Each side writes the byte under its own merge rules, so each processor controls only the fields that belong to it. Some handshake flags are also cleared as a side effect of a write.

Each processor also presents byte-granular 24-bit addresses on a request port. For each request the block checks whether the address falls in that side's word-memory window under the current organisation. It returns the 18-bit physical memory address, the byte lane and a valid flag one clock later.

In the split organisation the two processors always see opposite halves. The swap flag selects which half each side gets. Accesses outside a window, or in a window that the current organisation does not map, are reported invalid.

Top module: `wram_own_ctrl`

## Requirements
- R1: While reset is applied and until the first request is accepted, `ctl_reg` reads 0x00 and both valid outputs are 0.
- R2: A main-side write loads bits 7:6 (bank number) and bit 1 (handshake request flag, "req") from the data. Bits 4, 3, 2 (organisation, 1 = split) and 0 (swap flag, "swap") keep their old values. Bit 5 always reads 0.
- R3: If a main-side write leaves bit 2 = 0 and bit 1 = 1, bit 0 is cleared.
- R4: A sub-side write whose data has bit 2 = 1 loads bits 4, 3, 2 and 0 from the data and keeps bits 7:6 and 1. Bit 1 is cleared if bit 2 or bit 0 differs from the old value.
- R5: A sub-side write whose data has bit 2 = 0 loads bits 4, 3 and 2 from the data. Bit 0 becomes the OR of data bit 0 and old bit 0. Bits 7:6 and 1 are kept, and bit 1 is cleared if the new bit 0 is 1.
- R6: When both sides write in the same cycle, the main-side rule is applied first and the sub-side rule then acts on its result.
- R7: With bit 2 = 0, a main request in 0x200000–0x23FFFF is valid, with physical address equal to address bits 17:0.
- R8: With bit 2 = 1, a main request in 0x200000–0x21FFFF is valid, with physical address {addr[16:1], swap, addr[0]}. A request in 0x220000–0x23FFFF is invalid.
- R9: With bit 2 = 0, a sub request in 0x080000–0x0BFFFF is valid, with physical address equal to address bits 17:0. With bit 2 = 1 that window is invalid.
- R10: With bit 2 = 1, a sub request in 0x0C0000–0x0DFFFF is valid, with physical address {addr[16:1], NOT swap, addr[0]}. With bit 2 = 0 that window is invalid.
- R11: Translation results appear in the cycle after the request and use the control byte as it was in the request cycle. Without a request, or when the access is invalid, the valid output, the address and the lane are 0.
- R12: On a valid result the lane output equals address bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_wr_en | input | 1 | Main-side control byte write strobe |
| main_wr_data | input | 8 | Main-side control byte write data |
| sub_wr_en | input | 1 | Sub-side control byte write strobe |
| sub_wr_data | input | 8 | Sub-side control byte write data |
| ctl_reg | output | 8 | Current control byte |
| main_req | input | 1 | Main-side access request |
| main_addr | input | 24 | Main-side byte address |
| main_valid | output | 1 | Main access maps to word memory |
| main_phys | output | 18 | Main physical word-memory address |
| main_lane | output | 1 | Main byte lane |
| sub_req | input | 1 | Sub-side access request |
| sub_addr | input | 24 | Sub-side byte address |
| sub_valid | output | 1 | Sub access maps to word memory |
| sub_phys | output | 18 | Sub physical word-memory address |
| sub_lane | output | 1 | Sub byte lane |

## Verification
A wrong merge of the control byte is visible on `ctl_reg` in the cycle after the write. A handshake flag that is wrongly kept, cleared or OR-ed therefore shows up at once. The same error shows up again on the next translation in split mode, because bit 1 of the physical address follows the swap flag on one side and its inverse on the other. A window or organisation decode error appears as a wrong valid flag or address on the first request after the request cycle. The bench steps one cycle at a time and compares the control byte and both translation outputs against a reference model on every cycle.

// File: rtl/wram_own_pkg.sv
package wram_own_pkg;
  localparam int ADDR_W   = 24;
  localparam int PHYS_W   = 18;
  localparam int CTL_W    = 8;

  // control byte field positions (decoded by neighbours)
  localparam int B_SWAP   = 0;
  localparam int B_REQ    = 1;
  localparam int B_SPLIT  = 2;
  localparam int B_BANK_L = 6;

  localparam logic [CTL_W-1:0] MAIN_MASK = 8'hC2;
  localparam logic [CTL_W-1:0] SUB_MASK  = 8'h1D;

  typedef enum logic {SIDE_MAIN = 1'b0, SIDE_SUB = 1'b1} side_e;

  typedef struct packed {
    logic              valid;
    logic              lane;
    logic [PHYS_W-1:0] phys;
  } xlate_t;
endpackage

// File: rtl/wram_rst_sync.sv
module wram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/wram_mode_reg.sv
module wram_mode_reg
  import wram_own_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_we,
  input  logic [CTL_W-1:0] m_d,
  input  logic             s_we,
  input  logic [CTL_W-1:0] s_d,
  output logic [CTL_W-1:0] q
);
  logic [CTL_W-1:0] after_main;
  logic [CTL_W-1:0] nxt;
  logic             upd_en;

  function automatic logic [CTL_W-1:0] main_merge(input logic [CTL_W-1:0] old,
                                                  input logic [CTL_W-1:0] d);
    logic [CTL_W-1:0] r;
    r = (d & MAIN_MASK) | (old & SUB_MASK);
    if (!r[B_SPLIT] && r[B_REQ]) r[B_SWAP] = 1'b0;
    return r;
  endfunction

  function automatic logic [CTL_W-1:0] sub_merge(input logic [CTL_W-1:0] old,
                                                 input logic [CTL_W-1:0] d);
    logic [CTL_W-1:0] r;
    logic [CTL_W-1:0] dm;
    dm = d & SUB_MASK;
    if (dm[B_SPLIT]) begin
      r = dm | (old & MAIN_MASK);
      if ((r[B_SPLIT] != old[B_SPLIT]) || (r[B_SWAP] != old[B_SWAP]))
        r[B_REQ] = 1'b0;
    end else begin
      r = dm | (old & (MAIN_MASK | 8'h01));
      if (r[B_SWAP]) r[B_REQ] = 1'b0;
    end
    return r;
  endfunction

  always_comb begin
    after_main = m_we ? main_merge(q, m_d) : q;
    nxt        = s_we ? sub_merge(after_main, s_d) : after_main;
    upd_en     = m_we | s_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= nxt;
  end
endmodule

// File: rtl/wram_xlate.sv
module wram_xlate
  import wram_own_pkg::*;
#(
  parameter side_e       SIDE     = SIDE_MAIN,
  parameter logic [23:0] WIN_FULL = 24'h200000,
  parameter logic [23:0] WIN_HALF = 24'h200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              split,
  input  logic              swap,
  output xlate_t            res
);
  localparam int HALF_W = PHYS_W - 1;

  logic   half_sel;
  logic   hit_full;
  logic   hit_half;
  xlate_t res_d;

  generate
    if (SIDE == SIDE_SUB) begin : g_sub
      assign half_sel = ~swap;
    end else begin : g_main
      assign half_sel = swap;
    end
  endgenerate

  always_comb begin
    hit_full = (addr[ADDR_W-1:PHYS_W] == WIN_FULL[ADDR_W-1:PHYS_W]);
    hit_half = (addr[ADDR_W-1:HALF_W] == WIN_HALF[ADDR_W-1:HALF_W]);
    res_d    = '0;
    res_d.valid = req & (split ? hit_half : hit_full);
    if (res_d.valid) begin
      res_d.lane = addr[0];
      res_d.phys = split ? {addr[HALF_W-1:1], half_sel, addr[0]} : addr[PHYS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res <= '0;
    else        res <= res_d;
  end
endmodule

// File: rtl/wram_own_ctrl.sv
module wram_own_ctrl
  import wram_own_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_wr_en,
  input  logic [CTL_W-1:0]  main_wr_data,
  input  logic              sub_wr_en,
  input  logic [CTL_W-1:0]  sub_wr_data,
  output logic [CTL_W-1:0]  ctl_reg,
  input  logic              main_req,
  input  logic [ADDR_W-1:0] main_addr,
  output logic              main_valid,
  output logic [PHYS_W-1:0] main_phys,
  output logic              main_lane,
  input  logic              sub_req,
  input  logic [ADDR_W-1:0] sub_addr,
  output logic              sub_valid,
  output logic [PHYS_W-1:0] sub_phys,
  output logic              sub_lane
);
  logic   rst_sync_n;
  xlate_t m_res;
  xlate_t s_res;

  wram_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_sync_n)
  );

  wram_mode_reg u_reg (
    .clk(clk), .rst_n(rst_sync_n),
    .m_we(main_wr_en), .m_d(main_wr_data),
    .s_we(sub_wr_en),  .s_d(sub_wr_data),
    .q(ctl_reg)
  );

  wram_xlate #(.SIDE(SIDE_MAIN), .WIN_FULL(24'h200000), .WIN_HALF(24'h200000)) u_main_x (
    .clk(clk), .rst_n(rst_sync_n), .req(main_req), .addr(main_addr),
    .split(ctl_reg[B_SPLIT]), .swap(ctl_reg[B_SWAP]), .res(m_res)
  );

  wram_xlate #(.SIDE(SIDE_SUB), .WIN_FULL(24'h080000), .WIN_HALF(24'h0C0000)) u_sub_x (
    .clk(clk), .rst_n(rst_sync_n), .req(sub_req), .addr(sub_addr),
    .split(ctl_reg[B_SPLIT]), .swap(ctl_reg[B_SWAP]), .res(s_res)
  );

  assign main_valid = m_res.valid;
  assign main_phys  = m_res.phys;
  assign main_lane  = m_res.lane;
  assign sub_valid  = s_res.valid;
  assign sub_phys   = s_res.phys;
  assign sub_lane   = s_res.lane;
endmodule

// File: rtl/wram_own_chk.sv
module wram_own_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        main_wr_en,
  input logic        sub_wr_en,
  input logic [7:0]  sub_wr_data,
  input logic [7:0]  ctl_reg,
  input logic        main_req,
  input logic [23:0] main_addr,
  input logic        main_valid,
  input logic [17:0] main_phys,
  input logic        main_lane,
  input logic        sub_req,
  input logic        sub_valid,
  input logic [17:0] sub_phys
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) past_ok <= 1'b0;
    else          past_ok <= 1'b1;
  end

  AST_MAIN_NOREQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && !main_req) |=> !main_valid); // R11
  AST_SUB_NOREQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && !sub_req) |=> !sub_valid); // R11
  AST_MAIN_HALF: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && main_req && ctl_reg[2]) |=> (!main_valid || main_phys[1] == $past(ctl_reg[0]))); // R8
  AST_SUB_HALF: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && sub_req && ctl_reg[2]) |=> (!sub_valid || sub_phys[1] != $past(ctl_reg[0]))); // R10
  AST_MAIN_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && main_wr_en && !sub_wr_en) |=> (ctl_reg[4:2] == $past(ctl_reg[4:2]))); // R2
  AST_SUB_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && sub_wr_en && !main_wr_en) |=> (ctl_reg[7:6] == $past(ctl_reg[7:6]))); // R4
  AST_WHOLE_EXCL: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && sub_wr_en && !main_wr_en && !sub_wr_data[2]) |=> !(ctl_reg[1] && ctl_reg[0])); // R5
  AST_BIT5_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok |-> !ctl_reg[5]); // R2
  AST_MAIN_LANE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && main_req) |=> (!main_valid || main_lane == $past(main_addr[0]))); // R12
endmodule

bind wram_own_ctrl wram_own_chk u_chk (
  .clk(clk), .rst_q_n(rst_sync_n),
  .main_wr_en(main_wr_en), .sub_wr_en(sub_wr_en), .sub_wr_data(sub_wr_data),
  .ctl_reg(ctl_reg),
  .main_req(main_req), .main_addr(main_addr), .main_valid(main_valid),
  .main_phys(main_phys), .main_lane(main_lane),
  .sub_req(sub_req), .sub_valid(sub_valid), .sub_phys(sub_phys)
);

// File: tb/sim_wram_own_ctrl.sv
module sim_wram_own_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        main_wr_en, sub_wr_en, main_req, sub_req;
  logic [7:0]  main_wr_data, sub_wr_data;
  logic [23:0] main_addr, sub_addr;
  logic [7:0]  ctl_reg;
  logic        main_valid, main_lane, sub_valid, sub_lane;
  logic [17:0] main_phys, sub_phys;

  int checks = 0;
  int bad = 0;
  logic [7:0] model;

  always #10 clk = ~clk;

  wram_own_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .main_wr_en(main_wr_en), .main_wr_data(main_wr_data),
    .sub_wr_en(sub_wr_en), .sub_wr_data(sub_wr_data),
    .ctl_reg(ctl_reg),
    .main_req(main_req), .main_addr(main_addr),
    .main_valid(main_valid), .main_phys(main_phys), .main_lane(main_lane),
    .sub_req(sub_req), .sub_addr(sub_addr),
    .sub_valid(sub_valid), .sub_phys(sub_phys), .sub_lane(sub_lane)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: main side owns bank and request flag
  function automatic logic [7:0] ref_main(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    r[7:6] = d[7:6];
    r[1]   = d[1];
    r[5]   = 1'b0;
    if (r[2] == 1'b0 && r[1]) r[0] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] ref_sub(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    r[5] = 1'b0;
    r[4:2] = d[4:2];
    if (d[2]) begin
      r[0] = d[0];
      if (r[2] != c[2] || r[0] != c[0]) r[1] = 1'b0;
    end else begin
      r[0] = d[0] | c[0];
      if (r[0]) r[1] = 1'b0;
    end
    return r;
  endfunction

  // returns {valid, lane, phys}
  function automatic logic [19:0] ref_x(input bit is_sub, input logic req,
                                        input logic [23:0] a, input logic [7:0] c,
                                        output string tag);
    logic v;
    logic sel;
    v = 1'b0;
    sel = is_sub ? ~c[0] : c[0];
    if (!is_sub) begin
      tag = c[2] ? "R8" : "R7";
      v = c[2] ? (a >= 24'h200000 && a < 24'h220000) : (a >= 24'h200000 && a < 24'h240000);
    end else begin
      tag = c[2] ? "R10" : "R9";
      v = c[2] ? (a >= 24'h0C0000 && a < 24'h0E0000) : (a >= 24'h080000 && a < 24'h0C0000);
    end
    if (!req) begin tag = "R11"; v = 1'b0; end
    if (!v) return 20'h0;
    if (c[2]) return {1'b1, a[0], a[16:1], sel, a[0]};
    return {1'b1, a[0], a[17:0]};
  endfunction

  task automatic step(input logic mwe, input logic [7:0] md, input logic swe, input logic [7:0] sd,
                      input logic mrq, input logic [23:0] ma, input logic srq, input logic [23:0] sa);
    logic [19:0] em, es;
    string tm, ts;
    em = ref_x(1'b0, mrq, ma, model, tm);
    es = ref_x(1'b1, srq, sa, model, ts);
    if (mwe) model = ref_main(model, md);
    if (swe) model = ref_sub(model, sd);
    main_wr_en = mwe; main_wr_data = md; sub_wr_en = swe; sub_wr_data = sd;
    main_req = mrq; main_addr = ma; sub_req = srq; sub_addr = sa;
    @(posedge clk);
    @(negedge clk);
    chk((mwe && swe) ? "R6 ctl" : (mwe ? "R2/R3 ctl" : (swe ? "R4/R5 ctl" : "R2 hold")), {24'h0, ctl_reg}, {24'h0, model});
    chk({tm, " main"}, {12'h0, main_valid, main_lane, main_phys}, {12'h0, em});
    chk({ts, " sub"}, {12'h0, sub_valid, sub_lane, sub_phys}, {12'h0, es});
    if (em[19]) chk("R12 main lane", {31'h0, main_lane}, {31'h0, ma[0]});
  endtask

  function automatic logic [23:0] pick_addr();
    logic [23:0] base;
    case ($urandom_range(0, 5))
      0: base = 24'h200000;
      1: base = 24'h220000;
      2: base = 24'h080000;
      3: base = 24'h0C0000;
      4: base = 24'h0E0000;
      default: base = {$urandom_range(0, 127), 17'h0};
    endcase
    return base | 24'($urandom_range(0, 24'h1FFFF));
  endfunction

  initial begin
    #4_000_000;
    bad++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model = 8'h00;
    rst_n = 1'b0;
    main_wr_en = 0; sub_wr_en = 0; main_req = 0; sub_req = 0;
    main_wr_data = 0; sub_wr_data = 0; main_addr = 0; sub_addr = 0;
    repeat (3) @(negedge clk);
    chk("R1 ctl", {24'h0, ctl_reg}, 32'h0);
    chk("R1 valid", {30'h0, main_valid, sub_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ctl after release", {24'h0, ctl_reg}, 32'h0);

    // directed ownership sequence
    step(1, 8'hFF, 0, 8'h00, 0, 0, 0, 0);                 // R2 R3: expect C2
    chk("R3 main 2M req clears swap", {24'h0, ctl_reg}, 32'hC2);
    step(0, 8'h00, 1, 8'h01, 0, 0, 0, 0);                 // R5: expect C1
    chk("R5 sub 2M return", {24'h0, ctl_reg}, 32'hC1);
    step(1, 8'h02, 0, 8'h00, 0, 0, 0, 0);                 // R3: expect 02
    chk("R3 swap cleared", {24'h0, ctl_reg}, 32'h02);
    step(0, 8'h00, 1, 8'h04, 0, 0, 0, 0);                 // R4: expect 04
    chk("R4 split switch clears req", {24'h0, ctl_reg}, 32'h04);
    step(1, 8'h02, 0, 8'h00, 0, 0, 0, 0);                 // R2: expect 06
    chk("R2 split keeps swap", {24'h0, ctl_reg}, 32'h06);
    step(0, 8'h00, 1, 8'h05, 0, 0, 0, 0);                 // R4: expect 05
    chk("R4 swap change clears req", {24'h0, ctl_reg}, 32'h05);
    // split translations with swap=1
    step(0, 0, 0, 0, 1, 24'h200006, 1, 24'h0C0007);
    chk("R8 main half", {14'h0, main_valid, main_phys}, {14'h0, 1'b1, 18'h0000E});
    chk("R10 sub half", {14'h0, sub_valid, sub_phys}, {14'h0, 1'b1, 18'h0000D});
    step(0, 0, 0, 0, 1, 24'h220000, 1, 24'h080000);
    chk("R8 upper half invalid", {31'h0, main_valid}, 32'h0);
    chk("R9 whole window invalid in split", {31'h0, sub_valid}, 32'h0);
    // simultaneous writes: expect C1
    step(1, 8'hC0, 1, 8'h00, 0, 0, 0, 0);
    chk("R6 ordering", {24'h0, ctl_reg}, 32'hC1);
    step(0, 0, 0, 0, 1, 24'h23FFFF, 1, 24'h0BFFFE);
    chk("R7 main top", {13'h0, main_valid, main_lane, main_phys}, {13'h0, 2'b11, 18'h3FFFF});
    chk("R9 sub top", {14'h0, sub_valid, sub_phys}, {14'h0, 1'b1, 18'h3FFFE});
    step(0, 0, 0, 0, 1, 24'h0C0000, 1, 24'h0C0000);
    chk("R10 half window invalid in whole", {30'h0, main_valid, sub_valid}, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 3) == 0, 8'($urandom),
           $urandom_range(0, 3) != 0, pick_addr(), $urandom_range(0, 3) != 0, pick_addr());
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule